// File: doc/BRIEF.md
# Snooping Three-State Cache Controller

This block is the per-processor controller of a small direct-mapped cache that sits on a shared snooping bus. Every line is held in one of three states: invalid, shared (clean, possibly held elsewhere) or exclusive (dirty, the only copy). The processor side takes single read or write requests. It either answers at once from the cache or stalls until a bus transaction has finished.

On the bus side the controller raises a request, holds a command, an address and write data, and completes when the bus grants it for one cycle. It issues three kinds of transaction: a fill for reading, a fill for writing that takes ownership, and a victim writeback. It also watches every transaction of the other caches. It yields its own line or gives up ownership when another cache misses on a line it holds. While a snoop is being served, the controller's own processor request waits.

Top module: `snoop_cache_ctrl`

## Requirements
- R1: After reset every line is invalid, so the first access to any address needs a bus transaction, and `bus_req` and `cpu_ready` are low while no request is present.
- R2: A read whose tag matches a shared or exclusive line completes in the same cycle (`cpu_ready` high, `bus_req` low) and returns the cached data.
- R3: A read to an invalid line issues a read fill (`bus_cmd` = 2'b01) at the read address. On grant it returns `bus_rdata`, and the line becomes shared.
- R4: A read whose index holds a different tag in the shared state issues only a read fill, with no writeback.
- R5: A read whose index holds a different tag in the exclusive state first issues a writeback (`bus_cmd` = 2'b11) of the victim's address and data, then a read fill.
- R6: A write that hits an exclusive line updates the cache in the same cycle with no bus transaction.
- R7: A write that hits a shared line issues a write fill (`bus_cmd` = 2'b10), after which the line is exclusive and holds the written data.
- R8: A write to an invalid line, or to an index holding another tag as shared, issues one write fill. If the index holds another tag as exclusive, a writeback comes first.
- R9: A snooped read fill (`snp_cmd` = 2'b01) to a line held shared leaves the line shared and keeps `snp_flush` low.
- R10: A snooped read fill to a line held exclusive raises `snp_flush` with the line's data in the same cycle, and the line becomes shared.
- R11: A snooped write fill (`snp_cmd` = 2'b10) to a held line invalidates it. If the line was exclusive, its data is flushed first.
- R12: In any cycle with `snp_valid` high, the processor request neither completes nor drives `bus_req`. The snoop's state change is applied before that request is decoded again.
- R13: With two controllers on one bus, a line is exclusive in at most one of them: after one cache takes ownership, the other must issue a write fill to write it again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address of the request |
| cpu_wdata | input | DATA_W | Write data |
| cpu_rdata | output | DATA_W | Read data, valid with `cpu_ready` |
| cpu_ready | output | 1 | Request completes this cycle |
| bus_req | output | 1 | Bus transaction wanted |
| bus_gnt | input | 1 | One-cycle grant: transaction done this cycle |
| bus_cmd | output | 2 | 01 read fill, 10 write fill, 11 writeback |
| bus_addr | output | ADDR_W | Transaction address (victim address for writeback) |
| bus_wdata | output | DATA_W | Writeback data |
| bus_rdata | input | DATA_W | Fill data, valid with `bus_gnt` |
| snp_valid | input | 1 | Another cache's transaction is on the bus |
| snp_cmd | input | 2 | Snooped command (01 or 10) |
| snp_addr | input | ADDR_W | Snooped address |
| snp_flush | output | 1 | This cache supplies the snooped line |
| snp_data | output | DATA_W | Supplied line data |

## Verification
The hardest situation to reach is a snoop that arrives while this controller has a request stalled. For R12, the snoop has to change the very line the stalled request is about to evict. The bench gives the second controller bus priority for one scenario. It starts both processors in the same cycle: this cache wants to evict its exclusive line, and the other cache reads that line. The other cache's read is served first and turns the victim shared, so the stalled request must then skip the writeback. The count of writebacks seen at the bus shows whether the snoop was applied first.

// File: rtl/snc_pkg.sv
package snc_pkg;

    typedef enum logic [1:0] {
        LS_INV = 2'b00,
        LS_SHR = 2'b01,
        LS_EXC = 2'b10
    } line_state_e;

    typedef enum logic [1:0] {
        BC_NONE  = 2'b00,
        BC_RFILL = 2'b01,
        BC_WFILL = 2'b10,
        BC_WBACK = 2'b11
    } bus_cmd_e;

    // Result of a snoop lookup against one line.
    typedef struct packed {
        logic        flush;
        logic        upd;
        line_state_e nstate;
    } snoop_act_t;

    function automatic logic line_holds(input line_state_e st);
        return st != LS_INV;
    endfunction

    function automatic snoop_act_t snoop_decide(input logic valid, input bus_cmd_e cmd,
                                                input logic tag_eq, input line_state_e st);
        snoop_act_t a;
        logic held;
        held     = valid && tag_eq && line_holds(st);
        a.flush  = held && (st == LS_EXC) && (cmd == BC_RFILL || cmd == BC_WFILL);
        a.upd    = held && ((cmd == BC_WFILL) || (cmd == BC_RFILL && st == LS_EXC));
        a.nstate = (cmd == BC_WFILL) ? LS_INV : LS_SHR;
        return a;
    endfunction

endpackage

// File: rtl/snc_line_store.sv
module snc_line_store
    import snc_pkg::*;
#(
    parameter int IDX_W  = 2,
    parameter int TAG_W  = 6,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  a_idx,
    output line_state_e       a_st,
    output logic [TAG_W-1:0]  a_tag,
    output logic [DATA_W-1:0] a_data,
    input  logic [IDX_W-1:0]  b_idx,
    output line_state_e       b_st,
    output logic [TAG_W-1:0]  b_tag,
    output logic [DATA_W-1:0] b_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  line_state_e       wr_st,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [DATA_W-1:0] wr_data
);
    localparam int LINES = 1 << IDX_W;

    line_state_e       st_q  [LINES];
    logic [TAG_W-1:0]  tag_q [LINES];
    logic [DATA_W-1:0] dat_q [LINES];

    generate
        for (genvar g = 0; g < LINES; g++) begin : g_line
            always_ff @(posedge clk) begin
                if (rst) begin
                    st_q[g]  <= LS_INV;
                    tag_q[g] <= '0;
                    dat_q[g] <= '0;
                end else if (wr_en && wr_idx == IDX_W'(g)) begin
                    st_q[g]  <= wr_st;
                    tag_q[g] <= wr_tag;
                    dat_q[g] <= wr_data;
                end
            end
        end
    endgenerate

    assign a_st   = st_q[a_idx];
    assign a_tag  = tag_q[a_idx];
    assign a_data = dat_q[a_idx];
    assign b_st   = st_q[b_idx];
    assign b_tag  = tag_q[b_idx];
    assign b_data = dat_q[b_idx];

endmodule

// File: rtl/snc_cpu_side.sv
module snc_cpu_side
    import snc_pkg::*;
#(
    parameter int IDX_W  = 2,
    parameter int TAG_W  = 6,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [TAG_W-1:0]  tag,
    input  logic [DATA_W-1:0] wdata,
    input  logic              snp_busy,
    input  line_state_e       l_st,
    input  logic [TAG_W-1:0]  l_tag,
    input  logic [DATA_W-1:0] l_data,
    input  logic              gnt,
    input  logic [DATA_W-1:0] fill_data,
    output logic              ready,
    output logic [DATA_W-1:0] rdata,
    output logic              breq,
    output bus_cmd_e          bcmd,
    output logic [IDX_W+TAG_W-1:0] baddr,
    output logic              upd,
    output line_state_e       upd_st,
    output logic [DATA_W-1:0] upd_data
);
    logic hit, victim_dirty, quick, active;

    always_comb begin
        hit          = line_holds(l_st) && (l_tag == tag);
        victim_dirty = (l_st == LS_EXC) && (l_tag != tag);
        quick        = hit && (!we || l_st == LS_EXC);
        active       = req && !snp_busy;

        if (victim_dirty)  bcmd = BC_WBACK;
        else if (we)       bcmd = BC_WFILL;
        else               bcmd = BC_RFILL;

        baddr    = victim_dirty ? {l_tag, idx} : {tag, idx};
        breq     = active && !quick;
        ready    = active && (quick || (gnt && bcmd != BC_WBACK));
        rdata    = quick ? l_data : fill_data;

        upd      = 1'b0;
        upd_st   = l_st;
        upd_data = l_data;
        if (active && quick && we) begin
            upd      = 1'b1;
            upd_st   = LS_EXC;
            upd_data = wdata;
        end else if (active && !quick && gnt) begin
            upd = 1'b1;
            unique case (bcmd)
                BC_WBACK: upd_st = LS_INV;
                BC_RFILL: begin upd_st = LS_SHR; upd_data = fill_data; end
                default:  begin upd_st = LS_EXC; upd_data = wdata;     end
            endcase
        end
    end

    // R12: a snooped transaction holds the processor side completely.
    a_r12_snoop_first: assert property (@(posedge clk) disable iff (rst)
        snp_busy |-> (!ready && !breq));

    // R5/R8: a writeback never completes the processor request.
    a_r5_wback_stalls: assert property (@(posedge clk) disable iff (rst)
        (breq && bcmd == BC_WBACK) |-> !ready);

    // R6: completing without a grant means no bus request.
    a_r6_quiet_hit: assert property (@(posedge clk) disable iff (rst)
        (ready && !gnt) |-> !breq);

endmodule

// File: rtl/snc_snoop_side.sv
module snc_snoop_side
    import snc_pkg::*;
#(
    parameter int TAG_W  = 6,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              valid,
    input  bus_cmd_e          cmd,
    input  logic [TAG_W-1:0]  tag,
    input  line_state_e       l_st,
    input  logic [TAG_W-1:0]  l_tag,
    input  logic [DATA_W-1:0] l_data,
    output logic              flush,
    output logic [DATA_W-1:0] flush_data,
    output logic              upd,
    output line_state_e       upd_st
);
    snoop_act_t act;

    always_comb begin
        act        = snoop_decide(valid, cmd, l_tag == tag, l_st);
        flush      = act.flush;
        flush_data = l_data;
        upd        = act.upd;
        upd_st     = act.nstate;
    end

    // R10/R11: data is supplied only in reply to a snooped transaction.
    a_r10_flush_on_snoop: assert property (@(posedge clk) disable iff (rst)
        flush |-> valid);

    // R9: a shared copy never supplies data.
    a_r9_shared_silent: assert property (@(posedge clk) disable iff (rst)
        (valid && l_st == LS_SHR) |-> !flush);

endmodule

// File: rtl/snoop_cache_ctrl.sv
module snoop_cache_ctrl
    import snc_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int IDX_W  = 2,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_ready,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic [1:0]        bus_cmd,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              snp_valid,
    input  logic [1:0]        snp_cmd,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              snp_flush,
    output logic [DATA_W-1:0] snp_data
);
    localparam int TAG_W = ADDR_W - IDX_W;

    logic [IDX_W-1:0]  c_idx, s_idx;
    logic [TAG_W-1:0]  c_tag, s_tag;
    line_state_e       c_st, s_st;
    logic [TAG_W-1:0]  c_ltag, s_ltag;
    logic [DATA_W-1:0] c_ldata, s_ldata;

    logic              c_upd, s_upd, wr_en;
    line_state_e       c_upd_st, s_upd_st, wr_st;
    logic [DATA_W-1:0] c_upd_data, wr_data;
    logic [TAG_W-1:0]  wr_tag;
    logic [IDX_W-1:0]  wr_idx;
    bus_cmd_e          c_cmd;

    assign c_idx = cpu_addr[IDX_W-1:0];
    assign c_tag = cpu_addr[ADDR_W-1:IDX_W];
    assign s_idx = snp_addr[IDX_W-1:0];
    assign s_tag = snp_addr[ADDR_W-1:IDX_W];

    snc_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) store_i (
        .clk(clk), .rst(rst),
        .a_idx(c_idx), .a_st(c_st), .a_tag(c_ltag), .a_data(c_ldata),
        .b_idx(s_idx), .b_st(s_st), .b_tag(s_ltag), .b_data(s_ldata),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_st(wr_st), .wr_tag(wr_tag), .wr_data(wr_data)
    );

    snc_cpu_side #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) cpu_i (
        .clk(clk), .rst(rst),
        .req(cpu_req), .we(cpu_we), .idx(c_idx), .tag(c_tag), .wdata(cpu_wdata),
        .snp_busy(snp_valid),
        .l_st(c_st), .l_tag(c_ltag), .l_data(c_ldata),
        .gnt(bus_gnt), .fill_data(bus_rdata),
        .ready(cpu_ready), .rdata(cpu_rdata),
        .breq(bus_req), .bcmd(c_cmd), .baddr(bus_addr),
        .upd(c_upd), .upd_st(c_upd_st), .upd_data(c_upd_data)
    );

    snc_snoop_side #(.TAG_W(TAG_W), .DATA_W(DATA_W)) snoop_i (
        .clk(clk), .rst(rst),
        .valid(snp_valid), .cmd(bus_cmd_e'(snp_cmd)), .tag(s_tag),
        .l_st(s_st), .l_tag(s_ltag), .l_data(s_ldata),
        .flush(snp_flush), .flush_data(snp_data),
        .upd(s_upd), .upd_st(s_upd_st)
    );

    // Snoop updates win the single write port; the processor side is idle then.
    always_comb begin
        if (s_upd) begin
            wr_en   = 1'b1;
            wr_idx  = s_idx;
            wr_st   = s_upd_st;
            wr_tag  = s_ltag;
            wr_data = s_ldata;
        end else begin
            wr_en   = c_upd;
            wr_idx  = c_idx;
            wr_st   = c_upd_st;
            wr_tag  = (c_cmd == BC_WBACK && !cpu_ready) ? c_ltag : c_tag;
            wr_data = c_upd_data;
        end
    end

    assign bus_cmd   = bus_req ? c_cmd : BC_NONE;
    assign bus_wdata = c_ldata;

    // R1: no bus activity without a processor request.
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !cpu_req |-> (!bus_req && !cpu_ready));

    // R12: the two write sources never collide.
    a_r12_one_writer: assert property (@(posedge clk) disable iff (rst)
        !(s_upd && c_upd));

endmodule

// File: tb/snoop_cache_ctrl_tb_top.sv
`timescale 1ns/1ps
module snoop_cache_ctrl_tb_top;
    localparam int AW = 8;
    localparam int DW = 16;
    localparam logic [1:0] RF = 2'b01, WF = 2'b10, WB = 2'b11;

    logic clk = 0, rst = 1;
    always #5 clk = ~clk;

    logic [1:0]    cpu_req = '0, cpu_we = '0, ready, breq, gnt = '0, snp_v = '0, flush;
    logic [AW-1:0] cpu_addr [2];
    logic [DW-1:0] cpu_wdata [2];
    logic [DW-1:0] cpu_rdata [2];
    logic [1:0]    bcmd [2];
    logic [AW-1:0] baddr [2];
    logic [DW-1:0] bwdata [2];
    logic [1:0]    snp_cmd [2];
    logic [AW-1:0] snp_addr [2];
    logic [DW-1:0] snp_data [2];
    logic [DW-1:0] bus_rdata = '0;

    logic [DW-1:0] mem [256];
    int cnt [2][4];
    int flushes [2];
    int prio_peer = 0;
    int vectors = 0, errors = 0, overlap = 0, r12_bad = 0;

    snoop_cache_ctrl dut_i (
        .clk(clk), .rst(rst), .cpu_req(cpu_req[0]), .cpu_we(cpu_we[0]),
        .cpu_addr(cpu_addr[0]), .cpu_wdata(cpu_wdata[0]), .cpu_rdata(cpu_rdata[0]),
        .cpu_ready(ready[0]), .bus_req(breq[0]), .bus_gnt(gnt[0]), .bus_cmd(bcmd[0]),
        .bus_addr(baddr[0]), .bus_wdata(bwdata[0]), .bus_rdata(bus_rdata),
        .snp_valid(snp_v[0]), .snp_cmd(snp_cmd[0]), .snp_addr(snp_addr[0]),
        .snp_flush(flush[0]), .snp_data(snp_data[0]));

    snoop_cache_ctrl peer_i (
        .clk(clk), .rst(rst), .cpu_req(cpu_req[1]), .cpu_we(cpu_we[1]),
        .cpu_addr(cpu_addr[1]), .cpu_wdata(cpu_wdata[1]), .cpu_rdata(cpu_rdata[1]),
        .cpu_ready(ready[1]), .bus_req(breq[1]), .bus_gnt(gnt[1]), .bus_cmd(bcmd[1]),
        .bus_addr(baddr[1]), .bus_wdata(bwdata[1]), .bus_rdata(bus_rdata),
        .snp_valid(snp_v[1]), .snp_cmd(snp_cmd[1]), .snp_addr(snp_addr[1]),
        .snp_flush(flush[1]), .snp_data(snp_data[1]));

    function automatic logic [DW-1:0] init_val(input logic [AW-1:0] a);
        return 16'h4000 + 16'(a) * 16'd37;
    endfunction

    // Bus model: one grant per cycle, the other cache snoops fills.
    int w, o;
    always @(negedge clk) begin
        gnt = '0; snp_v = '0;
        #1;
        if (!rst) begin
            w = -1;
            if (prio_peer != 0) w = breq[1] ? 1 : (breq[0] ? 0 : -1);
            else                w = breq[0] ? 0 : (breq[1] ? 1 : -1);
            if (w >= 0) begin
                o = 1 - w;
                gnt[w] = 1'b1;
                cnt[w][bcmd[w]]++;
                if (bcmd[w] == WB) begin
                    mem[baddr[w]] = bwdata[w];
                end else begin
                    snp_v[o] = 1'b1; snp_cmd[o] = bcmd[w]; snp_addr[o] = baddr[w];
                    #1;
                    if (flush[o]) begin
                        mem[baddr[w]] = snp_data[o];
                        flushes[o]++;
                    end
                    bus_rdata = mem[baddr[w]];
                end
            end
        end
    end

    // R12 monitor: a snooped cache never completes or requests.
    always @(negedge clk) begin
        #3;
        for (int c = 0; c < 2; c++) begin
            if (snp_v[c] && cpu_req[c]) overlap++;
            if (snp_v[c] && (ready[c] || breq[c])) r12_bad++;
        end
    end

    task automatic check(input string req, input string what, input longint act, input longint exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic cpu_op(input int c, input bit we, input logic [AW-1:0] a,
                          input logic [DW-1:0] d, output logic [DW-1:0] rd);
        int n = 0;
        @(negedge clk);
        cpu_req[c] = 1'b1; cpu_we[c] = we; cpu_addr[c] = a; cpu_wdata[c] = d;
        #3;
        while (!ready[c]) begin
            n++;
            if (n > 60) begin
                check("watchdog", "cpu_ready timeout", 0, 1);
                break;
            end
            @(negedge clk); #3;
        end
        rd = cpu_rdata[c];
        @(negedge clk);
        cpu_req[c] = 1'b0;
    endtask

    int snap [2][4];
    int fsnap [2];
    task automatic take_snap();
        for (int c = 0; c < 2; c++) begin
            fsnap[c] = flushes[c];
            for (int k = 0; k < 4; k++) snap[c][k] = cnt[c][k];
        end
    endtask
    function automatic int d_cnt(input int c, input int k);
        return cnt[c][k] - snap[c][k];
    endfunction

    logic [DW-1:0] rd;

    task automatic t_reset();
        check("R1", "bus_req idle", longint'(breq), 0);
        check("R1", "cpu_ready idle", longint'(ready), 0);
        take_snap();
        cpu_op(0, 0, 8'h10, 0, rd);
        check("R1", "first read fills", d_cnt(0, RF), 1);
        check("R3", "fill data", rd, init_val(8'h10));
    endtask

    task automatic t_hits();
        take_snap();
        cpu_op(0, 0, 8'h10, 0, rd);
        check("R2", "read hit bus txns", d_cnt(0, RF) + d_cnt(0, WF) + d_cnt(0, WB), 0);
        check("R2", "read hit data", rd, init_val(8'h10));
        take_snap();
        cpu_op(0, 1, 8'h10, 16'hA5A5, rd);
        check("R7", "write hit shared -> write fill", d_cnt(0, WF), 1);
        take_snap();
        cpu_op(0, 1, 8'h10, 16'h5A5A, rd);
        check("R6", "write hit exclusive quiet", d_cnt(0, WF) + d_cnt(0, RF) + d_cnt(0, WB), 0);
    endtask

    task automatic t_conflicts();
        take_snap();
        cpu_op(0, 0, 8'h20, 0, rd);
        check("R5", "dirty victim writeback", d_cnt(0, WB), 1);
        check("R5", "then read fill", d_cnt(0, RF), 1);
        check("R5", "victim data in memory", mem[8'h10], 16'h5A5A);
        check("R5", "conflict read data", rd, init_val(8'h20));
        take_snap();
        cpu_op(0, 0, 8'h10, 0, rd);
        check("R4", "shared victim no writeback", d_cnt(0, WB), 0);
        check("R4", "read fill", d_cnt(0, RF), 1);
        check("R4", "data from memory", rd, 16'h5A5A);
    endtask

    task automatic t_write_miss();
        take_snap();
        cpu_op(0, 1, 8'h11, 16'h1111, rd);
        check("R8", "invalid write fill", d_cnt(0, WF), 1);
        check("R8", "invalid no writeback", d_cnt(0, WB), 0);
        take_snap();
        cpu_op(0, 1, 8'h21, 16'h2121, rd);
        check("R8", "exclusive victim writeback", d_cnt(0, WB), 1);
        check("R8", "then write fill", d_cnt(0, WF), 1);
        check("R8", "victim data", mem[8'h11], 16'h1111);
        take_snap();
        cpu_op(0, 0, 8'h20, 0, rd);
        cpu_op(0, 1, 8'h10, 16'h0101, rd);
        check("R8", "shared victim write fill only", d_cnt(0, WB), 0);
    endtask

    task automatic t_snoop_read();
        cpu_op(0, 0, 8'h12, 0, rd);
        take_snap();
        cpu_op(1, 0, 8'h12, 0, rd);
        check("R9", "shared snoop no flush", flushes[0] - fsnap[0], 0);
        check("R9", "peer data from memory", rd, init_val(8'h12));
        take_snap();
        cpu_op(0, 0, 8'h12, 0, rd);
        check("R9", "line stays shared (hit)", d_cnt(0, RF), 0);

        cpu_op(0, 1, 8'h13, 16'h1313, rd);
        take_snap();
        cpu_op(1, 0, 8'h13, 0, rd);
        check("R10", "exclusive snoop flush", flushes[0] - fsnap[0], 1);
        check("R10", "peer gets supplied data", rd, 16'h1313);
        check("R10", "memory updated", mem[8'h13], 16'h1313);
        take_snap();
        cpu_op(0, 1, 8'h13, 16'h1414, rd);
        check("R10", "line now shared -> write fill", d_cnt(0, WF), 1);
        take_snap();
        cpu_op(1, 0, 8'h13, 0, rd);
        check("R11", "peer shared copy invalidated", d_cnt(1, RF), 1);
        check("R11", "peer reads new owner data", rd, 16'h1414);
    endtask

    task automatic t_snoop_write();
        cpu_op(0, 1, 8'h12, 16'h7777, rd);
        take_snap();
        cpu_op(1, 1, 8'h12, 16'h8888, rd);
        check("R11", "exclusive flushed on write snoop", flushes[0] - fsnap[0], 1);
        check("R11", "flushed data in memory", mem[8'h12], 16'h7777);
        take_snap();
        cpu_op(0, 0, 8'h12, 0, rd);
        check("R11", "dut line invalidated", d_cnt(0, RF), 1);
        check("R13", "peer owner supplies", rd, 16'h8888);
        take_snap();
        cpu_op(1, 1, 8'h12, 16'h9999, rd);
        check("R13", "peer lost exclusivity", d_cnt(1, WF), 1);
    endtask

    task automatic t_priority();
        logic [DW-1:0] r0, r1;
        prio_peer = 1;
        take_snap();
        fork
            cpu_op(0, 0, 8'h31, 0, r0);
            cpu_op(1, 0, 8'h21, 0, r1);
        join
        prio_peer = 0;
        check("R12", "snoop overlapped a request", longint'(overlap > 0), 1);
        check("R12", "no completion during snoop", r12_bad, 0);
        check("R12", "victim made shared first, no writeback", d_cnt(0, WB), 0);
        check("R12", "dut flushed to peer", flushes[0] - fsnap[0], 1);
        check("R12", "peer data", r1, 16'h2121);
        check("R12", "dut data", r0, init_val(8'h31));
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = init_val(AW'(i));
        for (int c = 0; c < 2; c++) begin
            flushes[c] = 0;
            cpu_addr[c] = '0; cpu_wdata[c] = '0; snp_cmd[c] = '0; snp_addr[c] = '0;
            for (int k = 0; k < 4; k++) cnt[c][k] = 0;
        end
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk); #3;
        t_reset();
        t_hits();
        t_conflicts();
        t_write_miss();
        t_snoop_read();
        t_snoop_write();
        t_priority();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        #100000;
        vectors++; errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule